// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions towards an Ethernet PHY. A host presents a request strobe with an operation select (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then generates the management clock and shifts a complete frame. Each frame opens with a full preamble of ones. The block drives the data line through an output-enable, so an external pad or wired bus resolves the line.

Reads end with the line released for a fixed 19-bit window. The block samples the PHY's answer in that window, and the 16 data bits appear on `rd_data` when the `done` strobe fires. Writes end with two extra clocks during which the line is released. A divider derived from the system clock and the target MDC rate keeps the management clock at or below the limit.

Top module: `mdio_master`

## Requirements
- R1: After reset the block is idle: `mdc` low, `mdio_oe` low, `busy` low, `done` low.
- R2: Each management bit lasts 2*HALF system clocks, with HALF = ceil(CLK_HZ / (2*MDC_HZ)). `mdc` is low for the first HALF clocks of the bit and high for the last HALF clocks, so the MDC rate never exceeds MDC_HZ (2.5 MHz by default).
- R3: Every transaction begins with 32 bit periods in which `mdio_oe` = 1 and `mdio_out` = 1.
- R4: A read then drives 16 header bits, MSB first: 1,1, then start 0,1, then opcode 1,0, then the PHY address (bit 4 first), then the register address (bit 4 first).
- R5: After the read header, `mdio_oe` is 0 for 19 bit periods. `mdio_in` is sampled on the last system clock before each rising `mdc`. The 19th sample is discarded, and the 16 samples before it (window bits 3 to 18) form `rd_data`, with the first of them as bit 15.
- R6: A write drives 32 bits after the preamble, MSB first: 0,1, then 0,1, then the PHY address, then the register address, then 1,0, then the 16 data bits (bit 15 first).
- R7: After the 32 write bits, `mdio_oe` is 0 for 2 more bit periods before the transaction ends.
- R8: `mdio_out` and `mdio_oe` never change while `mdc` is high; they change only together with `mdc` falling, or at the start of a transaction.
- R9: `busy` rises in the clock after an accepted request and stays high through the high half of the final bit. In the next clock `busy` is low and `done` is high for exactly one clock.
- R10: A request while `busy` is high is ignored: the frame in progress continues unchanged.
- R11: `rd_data` changes only at the end of a read; a write leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start request, accepted when idle |
| op_rd | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data to write |
| rd_data | output | 16 | Data from the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock end-of-transaction strobe |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Data line as seen by the master |

## Verification
The bench goes after the edges of the read window. The responder drives a one on the first turnaround bit and on the discarded final bit. A design that kept the wrong 16 of its 19 samples would therefore return a word shifted by one, with a stray one at an end. Address and data patterns of all ones, all zeros and alternating bits expose a reversed bit order or a misplaced field in either header.

A request raised in the middle of a frame checks that a design which re-latches the fields, or restarts, is caught by the per-clock comparison. Following a read with a write shows whether a design overwrites `rd_data` on a write. Checking `done` and `busy` in the clock after the last bit shows whether the end of the frame is off by one clock.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_HZ = 50_000_000,
  parameter int MDC_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        op_rd,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int HALF    = (CLK_HZ + 2*MDC_HZ - 1) / (2*MDC_HZ);
  localparam int PW      = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int PRE     = 32;
  localparam int RD_BITS = PRE + 16 + 19;
  localparam int WR_BITS = PRE + 32 + 2;

  logic          is_rd;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   wd_q;
  logic [PW-1:0] ph;
  logic [6:0]    k;
  logic [18:0]   sr;

  wire [15:0] rd_hdr = {4'b1101, 2'b10, phy_q, reg_q};
  wire [31:0] wr_frm = {2'b01, 2'b01, phy_q, reg_q, 2'b10, wd_q};
  wire [6:0]  last_k = is_rd ? 7'(RD_BITS-1) : 7'(WR_BITS-1);
  wire        ph_end = (ph == PW'(HALF-1));
  wire [6:0]  rd_idx = 7'(PRE+15) - k;
  wire [6:0]  wr_idx = 7'(PRE+31) - k;
  wire        in_win = is_rd && (k >= 7'(PRE+16));

  always_comb begin
    mdio_oe  = 1'b0;
    mdio_out = 1'b0;
    if (busy) begin
      if (k < 7'(PRE)) begin
        mdio_oe  = 1'b1;
        mdio_out = 1'b1;
      end else if (is_rd && k < 7'(PRE+16)) begin
        mdio_oe  = 1'b1;
        mdio_out = rd_hdr[rd_idx[3:0]];
      end else if (!is_rd && k < 7'(PRE+32)) begin
        mdio_oe  = 1'b1;
        mdio_out = wr_frm[wr_idx[4:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      is_rd   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wd_q    <= '0;
      ph      <= '0;
      k       <= '0;
      sr      <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy  <= 1'b1;
          is_rd <= op_rd;
          phy_q <= phy_addr;
          reg_q <= reg_addr;
          wd_q  <= wr_data;
          ph    <= '0;
          k     <= '0;
          mdc   <= 1'b0;
        end
      end else if (!ph_end) begin
        ph <= ph + 1'b1;
      end else begin
        ph <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (in_win) sr <= {sr[17:0], mdio_in};
        end else begin
          mdc <= 1'b0;
          if (k == last_k) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (is_rd) rd_data <= sr[16:1];
          end else begin
            k <= k + 1'b1;
          end
        end
      end
    end
  end
endmodule

module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_out,
  input logic mdio_oe
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  // R8
  stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mdio_master mdio_master_chk i_mdio_master_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 20;
  localparam int H = 10;

  logic clk = 0, rst_n = 0, req = 0, op_rd = 0, mdio_in = 1;
  logic [4:0] phy_addr = 0, reg_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic busy, done, mdc, mdio_out, mdio_oe;
  int checks = 0, errors = 0;
  logic [15:0] last_rd = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.CLK_HZ(50_000_000), .MDC_HZ(2_500_000)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .req(req), .op_rd(op_rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic run(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                     logic [15:0] rsp, bit poke);
    bit eo[$];
    bit ev[$];
    logic [15:0] hdr;
    logic [31:0] frm;
    string tag;
    int nb;
    for (int i = 0; i < 32; i++) begin eo.push_back(1); ev.push_back(1); end
    if (rd) begin
      hdr = {4'b1101, 2'b10, pa, ra};
      for (int i = 15; i >= 0; i--) begin eo.push_back(1); ev.push_back(hdr[i]); end
      for (int i = 0; i < 19; i++) begin eo.push_back(0); ev.push_back(0); end
    end else begin
      frm = {2'b01, 2'b01, pa, ra, 2'b10, wd};
      for (int i = 31; i >= 0; i--) begin eo.push_back(1); ev.push_back(frm[i]); end
      for (int i = 0; i < 2; i++) begin eo.push_back(0); ev.push_back(0); end
    end
    nb = eo.size();
    @(negedge clk);
    req = 1; op_rd = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    for (int c = 0; c < nb*2*H; c++) begin
      int k;
      bit hi;
      @(negedge clk);
      k = c / (2*H);
      hi = ((c / H) % 2) == 1;
      req = 0;
      if (poke && c == 300) begin
        // R10: request with other fields while busy
        req = 1; op_rd = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
      end
      if (rd && k >= 48) begin
        int j = k - 48;
        mdio_in = (j == 0) ? 1'b1 : (j == 1) ? 1'b0 : (j == 18) ? 1'b1 : rsp[15-(j-2)];
      end else mdio_in = 1'b1;
      if (k < 32) tag = "R3";
      else if (rd) tag = (k < 48) ? "R4" : "R5";
      else tag = (k < 64) ? "R6" : "R7";
      if (poke && c > 300) tag = "R10";
      if (hi) tag = "R8";
      chk("R2 mdc", 32'(mdc), 32'(hi));
      chk({tag, " oe"}, 32'(mdio_oe), 32'(eo[k]));
      if (eo[k]) chk({tag, " out"}, 32'(mdio_out), 32'(ev[k]));
      chk("R9 busy", 32'(busy), 32'd1);
      chk("R9 done low", 32'(done), 32'd0);
    end
    @(negedge clk);
    chk("R9 busy end", 32'(busy), 32'd0);
    chk("R9 done", 32'(done), 32'd1);
    chk("R1 mdc idle", 32'(mdc), 32'd0);
    chk("R1 oe idle", 32'(mdio_oe), 32'd0);
    if (rd) begin
      chk("R5 rd_data", 32'(rd_data), 32'(rsp));
      last_rd = rsp;
    end else chk("R11 rd_data kept", 32'(rd_data), 32'(last_rd));
    @(negedge clk);
    chk("R9 done pulse", 32'(done), 32'd0);
    chk("R10 no restart", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mdc", 32'(mdc), 32'd0);
    chk("R1 oe", 32'(mdio_oe), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    rst_n = 1;
    @(negedge clk);
    run(0, 5'h05, 5'h12, 16'hA5C3, 16'h0, 0);
    run(1, 5'h01, 5'h01, 16'h0, 16'h796D, 0);
    run(0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1);
    run(1, 5'h00, 5'h00, 16'h0, 16'h0000, 0);
    run(1, 5'h1A, 5'h05, 16'h0, 16'h8001, 1);
    run(0, 5'h00, 5'h00, 16'h0000, 16'h0, 0);
    run(1, 5'h15, 5'h0A, 16'h0, 16'h5555, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule